// File: doc/BRIEF.md
# Mode-Dependent Stack Pointer Unit

This block holds a 16-bit stack pointer and turns push and pop requests into single-byte accesses on a plain byte-wide memory port. A request moves either one byte or a two-byte word. Pushes store and then move the pointer down. Pops move the pointer up and then fetch. A separate load port writes the pointer directly.

An emulation-mode level confines the pointer to one fixed page. While that level is high, every new pointer value keeps only its low byte, and the high byte is forced to the page constant (0x01). This covers pushes, pops and direct loads, so a move past either end of the page wraps around inside the page. While the level is low, the full 16-bit pointer is kept and wraps modulo 2^16.

A request is accepted in one cycle. Its memory accesses follow one per cycle, starting the next cycle. A single-cycle done pulse then marks the end of the operation, and for pops it also marks that the read data is valid.

Top module: `stkptr_unit`

## Requirements
- R1: While reset is held and right after it is released, the pointer `sp` reads 0x01FF, `busy` and `done` are low and neither `mem_we` nor `mem_re` is asserted.
- R2: When `emu_mode` is high at the edge that updates the pointer, the new pointer is {0x01, low byte of the computed value}. When it is low, the full 16-bit computed value is kept and wraps modulo 2^16.
- R3: A byte push writes `wr_data[7:0]` at address `sp`, and the pointer then becomes sp-1 (forced per R2).
- R4: A byte pop first moves the pointer to sp+1 (forced per R2), reads the byte at that new address, and returns it as `rd_data` = {0x00, byte}.
- R5: A word push (`size_word`=1) writes `wr_data[15:8]` at P and then `wr_data[7:0]` at the next pointer P-1, leaving the pointer two steps down. Each step is forced per R2.
- R6: A word pop reads the low byte at P+1 and then the high byte at the following address, leaving the pointer two steps up and returning `rd_data` = {high, low}.
- R7: Accesses start in the cycle after a request is accepted, one per cycle, with `busy` high exactly during them. `done` is high for exactly one cycle, the cycle after the last access, and `rd_data` is valid in that cycle.
- R8: Push, pop and load requests that arrive while `busy` is high have no effect: no extra access and no pointer change.
- R9: When `push_req` and `pop_req` are both high in an idle cycle, only the push is performed.
- R10: When `load_en` is high in an idle cycle with no push or pop request, the pointer takes `load_val`, forced per R2, at the next edge, and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| emu_mode | input | 1 | High confines the pointer to page 0x01 |
| push_req | input | 1 | Push request, sampled when idle |
| pop_req | input | 1 | Pop request, sampled when idle |
| size_word | input | 1 | 1 selects a two-byte operation, 0 a single byte |
| wr_data | input | 16 | Data to push; bits 7:0 alone for a byte push |
| load_en | input | 1 | Direct pointer load request |
| load_val | input | 16 | Value for a direct pointer load |
| rd_data | output | 16 | Popped data, valid while done is high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after the final access |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory address of the current access |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, returned in the same cycle |

## Verification
On every cycle, the assertions check that a write is followed by a pointer one below the written address, and that a read leaves the pointer on the address just read. They also check page forcing whenever the pointer moves in emulation mode, that `done` never lasts two cycles or overlaps `busy`, and that no access happens outside a busy window. Only the bench scenarios can show the byte order of word transfers, the value assembled in `rd_data`, that requests are dropped while busy, push-over-pop priority, and the exact cycle in which `done` appears.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } stk_state_e;
endpackage

// File: rtl/stkptr_ptr.sv
module stkptr_ptr #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [PTR_W-BYTE_W-1:0] PAGE_HI = 'h01,
  parameter logic [PTR_W-1:0] RST_PTR = 'h01FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emu,
  input  logic             load_go,
  input  logic [PTR_W-1:0] load_val,
  input  logic             dec_en,
  input  logic             inc_en,
  output logic [PTR_W-1:0] sp_q,
  output logic [PTR_W-1:0] sp_up
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  function automatic logic [PTR_W-1:0] page_fix(input logic e, input logic [PTR_W-1:0] v);
    return e ? {PAGE_HI, v[BYTE_W-1:0]} : v;
  endfunction

  logic [PTR_W-1:0] sp_down;
  logic [PTR_W-1:0] sp_load;
  logic [PTR_W-1:0] sp_d;
  logic             sp_en;

  always_comb begin
    sp_up   = page_fix(emu, sp_q + ONE);
    sp_down = page_fix(emu, sp_q - ONE);
    sp_load = page_fix(emu, load_val);
    sp_en   = load_go | dec_en | inc_en;
    if (load_go)     sp_d = sp_load;
    else if (dec_en) sp_d = sp_down;
    else if (inc_en) sp_d = sp_up;
    else             sp_d = sp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= RST_PTR;
    else if (sp_en) sp_q <= sp_d;
  end
endmodule

// File: rtl/stkptr_ctrl.sv
module stkptr_ctrl
  import stkptr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic              size_word,
  input  logic              load_en,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              load_go,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [BYTE_W-1:0] wbyte,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  localparam int unsigned WORD_W = 2 * BYTE_W;

  stk_state_e        state_q, state_d;
  logic              beat_q, beat_d;
  logic              pop_q, pop_d;
  logic              word_q, word_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  logic [WORD_W-1:0] rdat_q, rdat_d;
  logic              done_q, done_d;
  logic              idle, start, last;

  always_comb begin
    idle    = (state_q == ST_IDLE);
    start   = idle & (push_req | pop_req);
    load_go = idle & load_en & ~push_req & ~pop_req;
    last    = ~word_q | beat_q;
    acc_wr  = ~idle & ~pop_q;
    acc_rd  = ~idle &  pop_q;
    wbyte   = (word_q & ~beat_q) ? wdat_q[WORD_W-1:BYTE_W] : wdat_q[BYTE_W-1:0];

    state_d = state_q;
    beat_d  = beat_q;
    pop_d   = pop_q;
    word_d  = word_q;
    wdat_d  = wdat_q;
    rdat_d  = rdat_q;
    done_d  = 1'b0;

    if (start) begin
      state_d = ST_ACCESS;
      beat_d  = 1'b0;
      pop_d   = ~push_req;
      word_d  = size_word;
      wdat_d  = wr_data;
      if (!push_req) rdat_d = '0;
    end else if (!idle) begin
      if (pop_q) begin
        if (beat_q) rdat_d[WORD_W-1:BYTE_W] = mem_rdata;
        else        rdat_d[BYTE_W-1:0]      = mem_rdata;
      end
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end else begin
        beat_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
      pop_q   <= 1'b0;
      word_q  <= 1'b0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      pop_q   <= pop_d;
      word_q  <= word_d;
      wdat_q  <= wdat_d;
      rdat_q  <= rdat_d;
      done_q  <= done_d;
    end
  end

  assign rd_data = rdat_q;
  assign busy    = ~idle;
  assign done    = done_q;
endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [PTR_W-BYTE_W-1:0] PAGE_HI = 'h01,
  parameter logic [PTR_W-1:0] RST_PTR = 'h01FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                emu_mode,
  input  logic                push_req,
  input  logic                pop_req,
  input  logic                size_word,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic                load_en,
  input  logic [PTR_W-1:0]    load_val,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic                busy,
  output logic                done,
  output logic [PTR_W-1:0]    sp,
  output logic [PTR_W-1:0]    mem_addr,
  output logic                mem_we,
  output logic                mem_re,
  output logic [BYTE_W-1:0]   mem_wdata,
  input  logic [BYTE_W-1:0]   mem_rdata
);
  logic             load_go, acc_wr, acc_rd;
  logic [PTR_W-1:0] sp_q, sp_up;

  stkptr_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .pop_req(pop_req), .size_word(size_word),
    .load_en(load_en), .wr_data(wr_data), .mem_rdata(mem_rdata),
    .load_go(load_go), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .wbyte(mem_wdata), .rd_data(rd_data), .busy(busy), .done(done)
  );

  stkptr_ptr #(.PTR_W(PTR_W), .BYTE_W(BYTE_W), .PAGE_HI(PAGE_HI), .RST_PTR(RST_PTR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .emu(emu_mode),
    .load_go(load_go), .load_val(load_val),
    .dec_en(acc_wr), .inc_en(acc_rd),
    .sp_q(sp_q), .sp_up(sp_up)
  );

  assign sp       = sp_q;
  assign mem_we   = acc_wr;
  assign mem_re   = acc_rd;
  assign mem_addr = acc_rd ? sp_up : sp_q;
endmodule

// File: rtl/stkptr_unit_chk.sv
module stkptr_unit_chk #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [PTR_W-BYTE_W-1:0] PAGE_HI = 'h01
) (
  input logic             clk,
  input logic             rst_n,
  input logic             emu_mode,
  input logic             busy,
  input logic             done,
  input logic [PTR_W-1:0] sp,
  input logic [PTR_W-1:0] mem_addr,
  input logic             mem_we,
  input logic             mem_re
);
  localparam logic [PTR_W-1:0]  ONE_P = PTR_W'(1);
  localparam logic [BYTE_W-1:0] ONE_B = BYTE_W'(1);

  a_r2_page_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sp) && $past(emu_mode)) |-> (sp[PTR_W-1:BYTE_W] == PAGE_HI));

  a_r3_write_then_dec: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == ($past(emu_mode) ? {PAGE_HI, $past(mem_addr[BYTE_W-1:0]) - ONE_B}
                                       : $past(mem_addr) - ONE_P)));

  a_r4_read_at_new_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp == $past(mem_addr)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_access_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_we, mem_re}) <= 1);
endmodule

bind stkptr_unit stkptr_unit_chk #(.PTR_W(PTR_W), .BYTE_W(BYTE_W), .PAGE_HI(PAGE_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .busy(busy), .done(done),
  .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/stkptr_unit_tb.sv
module stkptr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        emu_mode = 1'b1;
  logic        push_req = 1'b0, pop_req = 1'b0, size_word = 1'b0, load_en = 1'b0;
  logic [15:0] wr_data = '0, load_val = '0;
  logic [15:0] rd_data, sp, mem_addr;
  logic        busy, done, mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  logic [7:0]  mem_m [256];
  logic [15:0] wa [8];
  logic [7:0]  wd [8];
  logic [15:0] ra [8];
  int wcnt = 0, rcnt = 0;

  always #2 clk = ~clk;

  stkptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .push_req(push_req),
    .pop_req(pop_req), .size_word(size_word), .wr_data(wr_data),
    .load_en(load_en), .load_val(load_val), .rd_data(rd_data), .busy(busy),
    .done(done), .sp(sp), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem_m[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we) begin
      mem_m[mem_addr[7:0]] <= mem_wdata;
      if (wcnt < 8) begin wa[wcnt] <= mem_addr; wd[wcnt] <= mem_wdata; end
      wcnt <= wcnt + 1;
    end
    if (mem_re) begin
      if (rcnt < 8) ra[rcnt] <= mem_addr;
      rcnt <= rcnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issues one request at a negedge, waits for done, returns cycles from acceptance to done.
  task automatic run_op(input logic psh, input logic pp, input logic wrd, input logic [15:0] d,
                        output int cyc);
    @(negedge clk);
    wcnt = 0; rcnt = 0;
    push_req = psh; pop_req = pp; size_word = wrd; wr_data = d;
    @(negedge clk);
    push_req = 1'b0; pop_req = 1'b0;
    cyc = 0;
    while (!done && cyc < 6) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    chk("R1 sp", sp, 16'h01FF);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 strobes", {mem_we, mem_re}, 0);
  endtask

  task automatic t_byte_push;
    int c;
    run_op(1, 0, 0, 16'h00A5, c);
    chk("R7 byte latency", c, 1);
    chk("R3 write count", wcnt, 1);
    chk("R3 write addr", wa[0], 16'h01FF);
    chk("R3 write data", wd[0], 8'hA5);
    chk("R3 sp after", sp, 16'h01FE);
    @(negedge clk);
    chk("R7 done one cycle", done, 0);
  endtask

  task automatic t_word_push;
    int c;
    run_op(1, 0, 1, 16'h1234, c);
    chk("R7 word latency", c, 2);
    chk("R5 write count", wcnt, 2);
    chk("R5 first addr", wa[0], 16'h01FE);
    chk("R5 first data high", wd[0], 8'h12);
    chk("R5 second addr", wa[1], 16'h01FD);
    chk("R5 second data low", wd[1], 8'h34);
    chk("R5 sp after", sp, 16'h01FC);
  endtask

  task automatic t_word_pop;
    int c;
    run_op(0, 1, 1, 16'h0000, c);
    chk("R6 read count", rcnt, 2);
    chk("R6 first addr", ra[0], 16'h01FD);
    chk("R6 second addr", ra[1], 16'h01FE);
    chk("R6 rd_data", rd_data, 16'h1234);
    chk("R6 sp after", sp, 16'h01FE);
  endtask

  task automatic t_byte_pop;
    int c;
    run_op(0, 1, 0, 16'h0000, c);
    chk("R4 read addr", ra[0], 16'h01FF);
    chk("R4 rd_data", rd_data, 16'h00A5);
    chk("R4 sp after", sp, 16'h01FF);
  endtask

  task automatic t_emu_wrap;
    int c;
    mem_m[8'h00] = 8'h6C;
    run_op(0, 1, 0, 16'h0000, c);
    chk("R2 pop wraps in page addr", ra[0], 16'h0100);
    chk("R2 pop wraps sp", sp, 16'h0100);
    chk("R4 wrap data", rd_data, 16'h006C);
    run_op(1, 0, 0, 16'h0077, c);
    chk("R2 push at page bottom addr", wa[0], 16'h0100);
    chk("R2 push wraps sp", sp, 16'h01FF);
  endtask

  task automatic t_load;
    @(negedge clk);
    wcnt = 0; rcnt = 0;
    load_en = 1'b1; load_val = 16'h3456;
    @(negedge clk);
    load_en = 1'b0;
    chk("R10 emu load forced", sp, 16'h0156);
    chk("R10 no access", wcnt + rcnt, 0);
    emu_mode = 1'b0;
    load_en = 1'b1; load_val = 16'h0000;
    @(negedge clk);
    load_en = 1'b0;
    chk("R10 native load", sp, 16'h0000);
  endtask

  task automatic t_native_push;
    int c;
    run_op(1, 0, 0, 16'h00C3, c);
    chk("R2 native write addr", wa[0], 16'h0000);
    chk("R2 native full wrap", sp, 16'hFFFF);
    run_op(0, 1, 0, 16'h0000, c);
    chk("R2 native pop back", sp, 16'h0000);
    chk("R4 native data", rd_data, 16'h00C3);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    wcnt = 0; rcnt = 0;
    push_req = 1'b1; size_word = 1'b1; wr_data = 16'hBEEF;
    @(negedge clk);
    push_req = 1'b0;
    chk("R7 busy in access", busy, 1);
    pop_req = 1'b1; push_req = 1'b1; load_en = 1'b1; load_val = 16'h4444;
    @(negedge clk);
    pop_req = 1'b0; push_req = 1'b0; load_en = 1'b0;
    @(negedge clk);
    chk("R7 done after word", done, 1);
    @(negedge clk);
    @(negedge clk);
    chk("R8 writes while busy", wcnt, 2);
    chk("R8 reads while busy", rcnt, 0);
    chk("R8 sp unchanged by extras", sp, 16'hFFFE);
  endtask

  task automatic t_priority;
    int c;
    run_op(1, 1, 0, 16'h0011, c);
    chk("R9 push taken", wcnt, 1);
    chk("R9 no pop", rcnt, 0);
    chk("R9 sp", sp, 16'hFFFD);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_push();
    t_word_push();
    t_word_pop();
    t_byte_pop();
    t_emu_wrap();
    t_load();
    t_native_push();
    t_busy_ignore();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule